// File: doc/BRIEF.md
# Dual Exposure Time Controller

This block closes the exposure loop for an image sensor that alternates short and long integration frames. At the end of every frame the sensor's statistics reach the block as a stream of 64 histogram counts. Each beat also carries three sideband fields: the frame kind, the number of black pixels and the number of clipped pixels. From these the block works out how much of the frame landed in the useful half of the histogram. It rescales that kind's integration time toward a fixed target share of 0.8, then clamps the result. The value goes to the sensor only when the change is large enough to be worth a register write.

The statistics input is a valid/ready stream. A beat transfers on a rising edge where `stat_valid` and `stat_ready` are both high. While a frame is still arriving, `stat_ready` stays high, and the source may insert idle cycles between beats. After the final beat, the block computes its result with one serial divider used twice. During that time `stat_ready` is held low and the source must wait. The sideband fields are taken from the final beat only. Two exposure registers, one per kind, are always visible. A one-cycle strobe marks every write, together with the kind and the written value, so a sensor register interface can forward it.

Top module: `dex_exp_ctrl`

## Requirements
- R1: After reset `stat_ready` is high. Each frame is exactly 64 accepted beats. After the 64th beat is accepted, `stat_ready` is low for the next 2W+5 cycles, with W = max(ACC_W, EXP_W) + 15 (83 cycles with default parameters). Any update strobe for that frame appears in the first cycle in which `stat_ready` is high again.
- R2: Beats are histogram bins in ascending level order. For a short frame the block sums beats 0 to 31. For a long frame it sums beats 32 to 63. Bins in the other half have no effect.
- R3: `stat_long`, `stat_dark` and `stat_sat` are sampled on the 64th beat only. `stat_long`=0 selects the short kind, and its excluded count is `stat_dark`. `stat_long`=1 selects the long kind, and its excluded count is `stat_sat`. The other count has no effect.
- R4: The proportion is P = floor(sum * 32768 / D), saturated to 65535 (Q1.15), where D = N_PIX - excluded count, or 0 when the excluded count is at least N_PIX.
- R5: The candidate time is floor(prev * 26214 / P), where prev is the current register of the same kind and 26214 is 0.8 in Q1.15 rounded down.
- R6: When P < P_FLOOR (16 by default), including when D = 0, the candidate is `cfg_max`.
- R7: The candidate is first limited to at most `cfg_max`, then raised to at least `cfg_min`.
- R8: The register of the frame's kind takes the candidate only when |candidate - prev| >= `cfg_thresh`, for both increases and decreases. Otherwise it keeps its value and no strobe occurs. With `cfg_thresh` = 0 every frame writes.
- R9: A write raises `upd_strobe` for exactly one cycle, with `upd_long` giving the kind and `upd_value` equal to the register just written. The register of the other kind does not change.
- R10: Reset sets `exp_short` to INIT_SHORT and `exp_long` to INIT_LONG, and holds `upd_strobe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_valid | input | 1 | Statistics beat valid |
| stat_ready | output | 1 | Block accepts a beat |
| stat_bin | input | BIN_W | Histogram count of this beat |
| stat_long | input | 1 | Frame kind, 1 = long exposure (sampled on last beat) |
| stat_dark | input | CNT_W | Black pixel count (sampled on last beat) |
| stat_sat | input | CNT_W | Clipped pixel count (sampled on last beat) |
| cfg_thresh | input | EXP_W | Minimum change that triggers a write |
| cfg_min | input | EXP_W | Lowest allowed integration time |
| cfg_max | input | EXP_W | Highest allowed integration time |
| exp_short | output | EXP_W | Current short integration time |
| exp_long | output | EXP_W | Current long integration time |
| upd_strobe | output | 1 | One-cycle write request |
| upd_long | output | 1 | Kind of the write, 1 = long |
| upd_value | output | EXP_W | Value written |

## Verification
The assertions assume that `cfg_min` does not exceed `cfg_max`. They also assume that the three configuration inputs do not change while a frame is in flight or on the strobe cycle, because the range and threshold properties compare the strobed value with the configuration present in that cycle. The stimulus changes configuration only after the block has returned to idle and the strobe cycle has passed, and it always keeps the minimum at or below the maximum. Frames are offered only while `stat_ready` is high. Some frames include idle gaps between beats, so that the beat counting does not depend on back-to-back transfers.

// File: rtl/dex_pkg.sv
package dex_pkg;
  // fraction bits of the proportion format (Q1.15)
  localparam int PROP_FRAC = 15;
  // target share 0.8 in Q1.15, rounded down
  localparam int TARGET_Q = 26214;

  typedef enum logic [2:0] {
    ST_COLLECT,
    ST_LOAD_P,
    ST_WAIT_P,
    ST_LOAD_T,
    ST_WAIT_T,
    ST_APPLY
  } ctl_state_e;
endpackage

// File: rtl/dex_stat_capture.sv
module dex_stat_capture #(
  parameter int BINS  = 64,
  parameter int BIN_W = 16,
  parameter int CNT_W = 21,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_fire,
  input  logic [BIN_W-1:0] beat_bin,
  input  logic             beat_long,
  input  logic [CNT_W-1:0] beat_dark,
  input  logic [CNT_W-1:0] beat_sat,
  output logic             frame_end,
  output logic [ACC_W-1:0] sum_q,
  output logic             long_q,
  output logic [CNT_W-1:0] excl_q
);
  localparam int IDX_W = $clog2(BINS);
  localparam int HALF  = BINS / 2;

  logic [IDX_W-1:0] idx_q;
  logic             in_upper;
  logic [ACC_W-1:0] half_acc [2];
  logic [ACC_W-1:0] half_next [2];

  assign in_upper  = (idx_q >= IDX_W'(HALF));
  assign frame_end = beat_fire && (idx_q == IDX_W'(BINS - 1));

  // one accumulator per histogram half; the kind is only known at the end
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_next[h] = (in_upper == 1'(h)) ? half_acc[h] + ACC_W'(beat_bin)
                                              : half_acc[h];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        half_acc[h] <= '0;
      end else if (frame_end) begin
        half_acc[h] <= '0;
      end else if (beat_fire) begin
        half_acc[h] <= half_next[h];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      sum_q  <= '0;
      long_q <= 1'b0;
      excl_q <= '0;
    end else if (beat_fire) begin
      idx_q <= frame_end ? '0 : idx_q + 1'b1;
      if (frame_end) begin
        long_q <= beat_long;
        sum_q  <= beat_long ? half_next[1] : half_next[0];
        excl_q <= beat_long ? beat_sat : beat_dark;
      end
    end
  end
endmodule

// File: rtl/dex_rdiv.sv
module dex_rdiv #(
  parameter int W = 39
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         done
);
  localparam int STEP_W = $clog2(W + 1);

  logic [W-1:0]      dvd_q;
  logic [W-1:0]      dvs_q;
  logic [W:0]        rem_q;
  logic [STEP_W-1:0] step_q;
  logic [W:0]        rem_sh;
  logic [W:0]        rem_sub;
  logic              take;

  always_comb begin
    rem_sh  = {rem_q[W-1:0], dvd_q[W-1]};
    take    = (rem_sh >= {1'b0, dvs_q});
    rem_sub = rem_sh - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      rem_q  <= '0;
      quo    <= '0;
      step_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        dvd_q  <= num;
        dvs_q  <= den;
        rem_q  <= '0;
        quo    <= '0;
        step_q <= STEP_W'(W);
      end else if (step_q != '0) begin
        rem_q  <= take ? rem_sub : rem_sh;
        quo    <= {quo[W-2:0], take};
        dvd_q  <= {dvd_q[W-2:0], 1'b0};
        step_q <= step_q - 1'b1;
        if (step_q == STEP_W'(1)) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dex_exp_update.sv
module dex_exp_update #(
  parameter int EXP_W      = 16,
  parameter int INIT_SHORT = 1000,
  parameter int INIT_LONG  = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  logic             apply_long,
  input  logic [EXP_W-1:0] cand,
  input  logic [EXP_W-1:0] thresh,
  output logic [EXP_W-1:0] exp_short,
  output logic [EXP_W-1:0] exp_long,
  output logic             strobe,
  output logic             strobe_long,
  output logic [EXP_W-1:0] strobe_value
);
  localparam logic [EXP_W-1:0] INIT_V [2] = '{EXP_W'(INIT_SHORT), EXP_W'(INIT_LONG)};

  logic [EXP_W-1:0] exp_q [2];
  logic [EXP_W-1:0] prev;
  logic [EXP_W-1:0] delta;
  logic             do_write;

  assign prev     = apply_long ? exp_q[1] : exp_q[0];
  assign delta    = (cand >= prev) ? cand - prev : prev - cand;
  assign do_write = apply && (delta >= thresh);

  for (genvar k = 0; k < 2; k++) begin : g_kind
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        exp_q[k] <= INIT_V[k];
      end else if (do_write && (apply_long == 1'(k))) begin
        exp_q[k] <= cand;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe       <= 1'b0;
      strobe_long  <= 1'b0;
      strobe_value <= '0;
    end else begin
      strobe <= do_write;
      if (do_write) begin
        strobe_long  <= apply_long;
        strobe_value <= cand;
      end
    end
  end

  assign exp_short = exp_q[0];
  assign exp_long  = exp_q[1];
endmodule

// File: rtl/dex_exp_ctrl.sv
module dex_exp_ctrl #(
  parameter int BINS       = 64,
  parameter int BIN_W      = 16,
  parameter int CNT_W      = 21,
  parameter int ACC_W      = 24,
  parameter int EXP_W      = 16,
  parameter int N_PIX      = 1310720,
  parameter int P_FLOOR    = 16,
  parameter int INIT_SHORT = 1000,
  parameter int INIT_LONG  = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_valid,
  output logic             stat_ready,
  input  logic [BIN_W-1:0] stat_bin,
  input  logic             stat_long,
  input  logic [CNT_W-1:0] stat_dark,
  input  logic [CNT_W-1:0] stat_sat,
  input  logic [EXP_W-1:0] cfg_thresh,
  input  logic [EXP_W-1:0] cfg_min,
  input  logic [EXP_W-1:0] cfg_max,
  output logic [EXP_W-1:0] exp_short,
  output logic [EXP_W-1:0] exp_long,
  output logic             upd_strobe,
  output logic             upd_long,
  output logic [EXP_W-1:0] upd_value
);
  import dex_pkg::*;

  localparam int FRAC  = PROP_FRAC;
  localparam int P_W   = FRAC + 1;
  localparam int DIV_W = ((ACC_W > EXP_W) ? ACC_W : EXP_W) + FRAC;

  ctl_state_e       state_q;
  logic             beat_fire;
  logic             frame_end;
  logic [ACC_W-1:0] sum_q;
  logic             long_q;
  logic [CNT_W-1:0] excl_q;

  logic [P_W-1:0]   p_q;
  logic [EXP_W-1:0] cand_q;

  logic             div_start;
  logic [DIV_W-1:0] div_num;
  logic [DIV_W-1:0] div_den;
  logic [DIV_W-1:0] div_quo;
  logic             div_done;

  logic [DIV_W-1:0] n_ext, excl_ext, den_p;
  logic [DIV_W-1:0] prev_ext;
  logic [EXP_W-1:0] prev_exp;
  logic [P_W-1:0]   p_next;
  logic [DIV_W-1:0] max_ext, min_ext, cand_ext;
  logic [EXP_W-1:0] cand_next;

  assign stat_ready = (state_q == ST_COLLECT);
  assign beat_fire  = stat_valid && stat_ready;

  dex_stat_capture #(
    .BINS (BINS),
    .BIN_W(BIN_W),
    .CNT_W(CNT_W),
    .ACC_W(ACC_W)
  ) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_fire(beat_fire),
    .beat_bin (stat_bin),
    .beat_long(stat_long),
    .beat_dark(stat_dark),
    .beat_sat (stat_sat),
    .frame_end(frame_end),
    .sum_q    (sum_q),
    .long_q   (long_q),
    .excl_q   (excl_q)
  );

  // usable pixel count, zero when every pixel is excluded
  always_comb begin
    n_ext    = DIV_W'(N_PIX);
    excl_ext = DIV_W'(excl_q);
    den_p    = (excl_ext >= n_ext) ? '0 : n_ext - excl_ext;
  end

  assign prev_exp = long_q ? exp_long : exp_short;
  assign prev_ext = DIV_W'(prev_exp);

  // operand selection for the shared divider
  always_comb begin
    div_start = (state_q == ST_LOAD_P) || (state_q == ST_LOAD_T);
    if (state_q == ST_LOAD_T) begin
      div_num = prev_ext * DIV_W'(TARGET_Q);
      div_den = DIV_W'(p_q);
    end else begin
      div_num = DIV_W'({sum_q, {FRAC{1'b0}}});
      div_den = den_p;
    end
  end

  dex_rdiv #(
    .W(DIV_W)
  ) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(div_start),
    .num  (div_num),
    .den  (div_den),
    .quo  (div_quo),
    .done (div_done)
  );

  // proportion, saturated to the Q1.15 range
  always_comb begin
    if (den_p == '0) begin
      p_next = '0;
    end else if (div_quo > DIV_W'({P_W{1'b1}})) begin
      p_next = '1;
    end else begin
      p_next = div_quo[P_W-1:0];
    end
  end

  // candidate: floor override, then upper limit, then lower limit
  always_comb begin
    max_ext  = DIV_W'(cfg_max);
    min_ext  = DIV_W'(cfg_min);
    cand_ext = (p_q < P_W'(P_FLOOR)) ? max_ext : div_quo;
    if (cand_ext > max_ext) cand_ext = max_ext;
    if (cand_ext < min_ext) cand_ext = min_ext;
    cand_next = cand_ext[EXP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      p_q     <= '0;
      cand_q  <= '0;
    end else begin
      case (state_q)
        ST_COLLECT: if (frame_end) state_q <= ST_LOAD_P;
        ST_LOAD_P:  state_q <= ST_WAIT_P;
        ST_WAIT_P: begin
          if (div_done) begin
            p_q     <= p_next;
            state_q <= ST_LOAD_T;
          end
        end
        ST_LOAD_T:  state_q <= ST_WAIT_T;
        ST_WAIT_T: begin
          if (div_done) begin
            cand_q  <= cand_next;
            state_q <= ST_APPLY;
          end
        end
        ST_APPLY:   state_q <= ST_COLLECT;
        default:    state_q <= ST_COLLECT;
      endcase
    end
  end

  dex_exp_update #(
    .EXP_W     (EXP_W),
    .INIT_SHORT(INIT_SHORT),
    .INIT_LONG (INIT_LONG)
  ) u_update (
    .clk         (clk),
    .rst_n       (rst_n),
    .apply       (state_q == ST_APPLY),
    .apply_long  (long_q),
    .cand        (cand_q),
    .thresh      (cfg_thresh),
    .exp_short   (exp_short),
    .exp_long    (exp_long),
    .strobe      (upd_strobe),
    .strobe_long (upd_long),
    .strobe_value(upd_value)
  );
endmodule

// File: rtl/dex_ctrl_chk.sv
module dex_ctrl_chk #(
  parameter int BINS  = 64,
  parameter int EXP_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stat_valid,
  input logic             stat_ready,
  input logic [EXP_W-1:0] cfg_thresh,
  input logic [EXP_W-1:0] cfg_min,
  input logic [EXP_W-1:0] cfg_max,
  input logic [EXP_W-1:0] exp_short,
  input logic [EXP_W-1:0] exp_long,
  input logic             upd_strobe,
  input logic             upd_long,
  input logic [EXP_W-1:0] upd_value
);
  localparam int IDX_W = $clog2(BINS);

  logic [IDX_W-1:0] seen_q;
  logic             last_fire;

  assign last_fire = stat_valid && stat_ready && (seen_q == IDX_W'(BINS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else if (stat_valid && stat_ready) seen_q <= last_fire ? '0 : seen_q + 1'b1;
  end

  function automatic logic [EXP_W-1:0] gap(input logic [EXP_W-1:0] a, input logic [EXP_W-1:0] b);
    return (a >= b) ? a - b : b - a;
  endfunction

  assert_busy_after_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> !stat_ready);

  assert_strobe_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> stat_ready);

  assert_strobe_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> !upd_strobe);

  assert_value_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> (upd_value >= cfg_min) && (upd_value <= cfg_max));

  assert_strobe_matches_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> (upd_value == (upd_long ? exp_long : exp_short)));

  assert_short_moves_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_short != $past(exp_short)) |-> (upd_strobe && !upd_long));

  assert_long_moves_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_long != $past(exp_long)) |-> (upd_strobe && upd_long));

  assert_short_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe && !upd_long) |-> (gap(exp_short, $past(exp_short)) >= cfg_thresh));

  assert_long_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe && upd_long) |-> (gap(exp_long, $past(exp_long)) >= cfg_thresh));
endmodule

bind dex_exp_ctrl dex_ctrl_chk #(
  .BINS (BINS),
  .EXP_W(EXP_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stat_valid(stat_valid),
  .stat_ready(stat_ready),
  .cfg_thresh(cfg_thresh),
  .cfg_min   (cfg_min),
  .cfg_max   (cfg_max),
  .exp_short (exp_short),
  .exp_long  (exp_long),
  .upd_strobe(upd_strobe),
  .upd_long  (upd_long),
  .upd_value (upd_value)
);

// File: tb/dex_exp_ctrl_tb.sv
module dex_exp_ctrl_tb;
  localparam int  BIN_W  = 16;
  localparam int  CNT_W  = 21;
  localparam int  ACC_W  = 24;
  localparam int  EXP_W  = 16;
  localparam longint NPIX = 1310720;
  localparam int  PFLOOR = 16;
  localparam int  I_SH   = 1000;
  localparam int  I_LG   = 20000;
  localparam int  WDIV   = ((ACC_W > EXP_W) ? ACC_W : EXP_W) + 15;
  localparam int  LAT    = 2 * WDIV + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stat_valid = 1'b0;
  logic stat_ready;
  logic [BIN_W-1:0] stat_bin = '0;
  logic stat_long = 1'b0;
  logic [CNT_W-1:0] stat_dark = '0;
  logic [CNT_W-1:0] stat_sat = '0;
  logic [EXP_W-1:0] cfg_thresh = 16'd8;
  logic [EXP_W-1:0] cfg_min = 16'd16;
  logic [EXP_W-1:0] cfg_max = 16'd60000;
  logic [EXP_W-1:0] exp_short, exp_long, upd_value;
  logic upd_strobe, upd_long;

  always #10 clk = ~clk;

  dex_exp_ctrl #(
    .BINS(64), .BIN_W(BIN_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .EXP_W(EXP_W),
    .N_PIX(1310720), .P_FLOOR(PFLOOR), .INIT_SHORT(I_SH), .INIT_LONG(I_LG)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .stat_valid(stat_valid), .stat_ready(stat_ready),
    .stat_bin(stat_bin), .stat_long(stat_long), .stat_dark(stat_dark), .stat_sat(stat_sat),
    .cfg_thresh(cfg_thresh), .cfg_min(cfg_min), .cfg_max(cfg_max),
    .exp_short(exp_short), .exp_long(exp_long),
    .upd_strobe(upd_strobe), .upd_long(upd_long), .upd_value(upd_value)
  );

  int checks = 0;
  int errors = 0;
  int strobe_cnt = 0;
  bit finished = 1'b0;

  task automatic check_val(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  longint m_short, m_long, m_lo, m_hi;
  int     m_cnt, m_idx;
  bit     m_strobe, m_slong;
  longint m_sval;
  bit     pend_write, pend_long;
  longint pend_val;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_short = I_SH; m_long = I_LG; m_lo = 0; m_hi = 0;
      m_cnt = 0; m_idx = 0; m_strobe = 0; m_slong = 0; m_sval = 0;
      pend_write = 0; pend_long = 0; pend_val = 0;
    end else begin
      m_strobe = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0 && pend_write) begin
          if (pend_long) m_long = pend_val; else m_short = pend_val;
          m_strobe = 1; m_slong = pend_long; m_sval = pend_val;
        end
      end else if (stat_valid) begin
        if (m_idx < 32) m_lo += stat_bin; else m_hi += stat_bin;
        if (m_idx == 63) begin
          longint excl, d, p, prev, cand, diff, s;
          pend_long = stat_long;
          s    = stat_long ? m_hi : m_lo;
          excl = stat_long ? longint'(stat_sat) : longint'(stat_dark);
          d    = (excl >= NPIX) ? 0 : NPIX - excl;
          p    = (d == 0) ? 0 : (s * 32768) / d;
          if (p > 65535) p = 65535;
          prev = stat_long ? m_long : m_short;
          cand = (p < PFLOOR) ? longint'(cfg_max) : (prev * 26214) / p;
          if (cand > cfg_max) cand = cfg_max;
          if (cand < cfg_min) cand = cfg_min;
          diff = (cand >= prev) ? cand - prev : prev - cand;
          pend_write = (diff >= cfg_thresh);
          pend_val = cand;
          m_cnt = LAT; m_idx = 0; m_lo = 0; m_hi = 0;
        end else begin
          m_idx++;
        end
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check_val("R1", "stat_ready", longint'(stat_ready), longint'(m_cnt == 0));
      check_val("R9", "upd_strobe", longint'(upd_strobe), longint'(m_strobe));
      if (m_strobe) begin
        check_val("R9", "upd_long", longint'(upd_long), longint'(m_slong));
        check_val("R9", "upd_value", longint'(upd_value), m_sval);
      end
      check_val("R8", "exp_short", longint'(exp_short), m_short);
      check_val("R8", "exp_long", longint'(exp_long), m_long);
      if (upd_strobe) strobe_cnt++;
    end
  end

  task automatic send_frame(input bit lng, input int lo, input int first_hi, input int hi,
                            input int dark, input int sat, input bit gaps);
    @(negedge clk);
    while (!stat_ready) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      if (gaps && (i % 3 == 1)) begin
        stat_valid = 1'b0;
        @(negedge clk);
      end
      stat_valid = 1'b1;
      stat_bin   = (i < 32) ? BIN_W'(lo) : ((i == 32) ? BIN_W'(first_hi) : BIN_W'(hi));
      stat_long  = lng;
      stat_dark  = CNT_W'(dark);
      stat_sat   = CNT_W'(sat);
      @(negedge clk);
    end
    stat_valid = 1'b0;
  endtask

  task automatic run_frame(input string req, input bit lng, input int lo, input int first_hi,
                           input int hi, input int dark, input int sat, input bit gaps,
                           input int want_write, input int want_val);
    strobe_cnt = 0;
    send_frame(lng, lo, first_hi, hi, dark, sat, gaps);
    repeat (LAT + 4) @(negedge clk);
    check_val(req, "strobe count", strobe_cnt, want_write);
    check_val(req, lng ? "exp_long" : "exp_short",
              lng ? longint'(exp_long) : longint'(exp_short), want_val);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check_val("R10", "exp_short", exp_short, I_SH);
    check_val("R10", "exp_long", exp_long, I_LG);
    check_val("R10", "upd_strobe", upd_strobe, 0);
    check_val("R1", "stat_ready after reset", stat_ready, 1);

    // R2 R4 R5: short, lower half 20000 each, P=16000, 1000 -> 1638
    run_frame("R2", 1'b0, 20000, 1000, 1000, 0, 0, 1'b0, 1, 1638);
    // R3: long, saturated count excluded, P=26214, no change; dark ignored
    run_frame("R3", 1'b1, 65535, 30000, 30000, 500000, 110720, 1'b0, 0, 20000);
    // R8: short, candidate equals previous, below threshold
    run_frame("R8", 1'b0, 30000, 0, 0, 110720, 900000, 1'b0, 0, 1638);
    // R8: zero threshold writes the same value
    cfg_thresh = 16'd0;
    run_frame("R8", 1'b0, 30000, 0, 0, 110720, 900000, 1'b0, 1, 1638);
    cfg_thresh = 16'd8;
    // R6: every pixel dark, denominator zero -> max
    run_frame("R6", 1'b0, 20000, 0, 0, 1310720, 0, 1'b0, 1, 60000);
    // R6: near-zero proportion (P=7) on a long frame -> max
    run_frame("R6", 1'b1, 0, 300, 0, 0, 0, 1'b0, 1, 60000);
    // R4 R7: proportion saturates at 65535, candidate 24000 raised to min 30000
    cfg_min = 16'd30000;
    run_frame("R7", 1'b0, 65535, 0, 0, 1245184, 0, 1'b0, 1, 30000);
    cfg_min = 16'd16;
    // R7: candidate 98302 limited to max 50000
    cfg_max = 16'd50000;
    run_frame("R7", 1'b1, 0, 20000, 20000, 0, 0, 1'b0, 1, 50000);
    cfg_max = 16'd60000;
    // R1: idle gaps between beats; P=8000, 30000 -> 98302 -> 60000
    run_frame("R1", 1'b0, 10000, 0, 0, 0, 0, 1'b1, 1, 60000);
    // R9: the long register kept its value across the short writes
    check_val("R9", "exp_long untouched", exp_long, 50000);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule